// File: doc/BRIEF.md
# Dual-Scheme Serial Clock Divider

This block derives the serial clock of an SPI-style master from its module clock. A single scheme-select input picks one of two division laws. In the coarse scheme the module clock is divided by a power of two set by a 4-bit exponent. In the fine scheme it is divided by an even ratio set by an 8-bit count. Together the two schemes span ratios from 2 up to 65536.

The transfer engine raises the enable while a transfer runs. While the enable is high the block produces a free-running serial clock level and a one-cycle tick on every edge of that clock. The shift engine uses the tick to time its launch and capture work. While the enable is low the output rests at its idle level, the internal counter is held at zero, and the divider fields are captured. A field change therefore only takes effect from the next enable, which avoids a shortened clock pulse.

Top module: `sclk_divgen`

## Requirements
- R1: After reset, `sclk` is at the idle level (0 by default) and `tick` is 0.
- R2: With `lin_mode` = 0 (power-of-two scheme), `sclk` changes level every 2^E module clocks, giving a ratio of 2^(E+1), where E is `exp_sel`.
- R3: With `lin_mode` = 1 (linear scheme), `sclk` changes level every N+1 module clocks, giving a ratio of 2×(N+1), where N is `lin_div`.
- R4: The fastest setting (linear with N = 0, or power-of-two with E = 0) makes `sclk` change every module clock, which is half the module clock rate.
- R5: The slowest setting (power-of-two with E = 15) makes `sclk` change every 32768 module clocks, a ratio of 65536.
- R6: After `en` rises, the first `sclk` change away from idle comes exactly one half-period (in module clocks) after the first rising edge that samples `en` high.
- R7: `tick` is high for exactly one module clock at each `sclk` change, and low in every other enabled cycle.
- R8: Changes to `lin_mode`, `exp_sel` or `lin_div` while `en` is high do not alter the running period. The values present while `en` is low apply from the next enable.
- R9: One module clock after `en` is sampled low, `sclk` is at the idle level and `tick` is 0. The next enable starts a full half-period again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Divider run enable from the transfer engine |
| lin_mode | input | 1 | Scheme select: 1 linear, 0 power-of-two |
| exp_sel | input | EXP_W (4) | Power-of-two exponent E |
| lin_div | input | LIN_W (8) | Linear count N |
| tick | output | 1 | One-cycle strobe on each serial clock edge |
| sclk | output | 1 | Divided serial clock level |

## Verification
The assertions assume that the divider fields matter only while `en` is low. They also assume that `en` is a clean synchronous level from the transfer engine and never changes between clock edges. The stimulus meets these assumptions by changing inputs only on falling clock edges. It always parks the fields for at least two cycles with `en` low before it raises `en`. Some random cases deliberately change the fields while running, and that change is judged only against the output period, so it stays inside what the properties allow.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

  typedef enum logic {
    DIV_POW2   = 1'b0,
    DIV_LINEAR = 1'b1
  } div_scheme_e;

  function automatic int unsigned half_width(input int unsigned exp_w,
                                             input int unsigned lin_w);
    int unsigned pow_bits;
    pow_bits = (1 << exp_w);
    return (pow_bits > lin_w + 1) ? pow_bits : lin_w + 1;
  endfunction

endpackage

// File: rtl/sclk_ratio_sel.sv
module sclk_ratio_sel
  import sclk_div_pkg::*;
#(
  parameter int EXP_W  = 4,
  parameter int LIN_W  = 8,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              lin_mode,
  input  logic [EXP_W-1:0]  exp_sel,
  input  logic [LIN_W-1:0]  lin_div,
  output logic [HALF_W-1:0] half_q
);

  div_scheme_e       scheme;
  logic [HALF_W-1:0] half_calc;

  assign scheme = div_scheme_e'(lin_mode);

  always_comb begin
    if (scheme == DIV_LINEAR)
      half_calc = HALF_W'(lin_div) + HALF_W'(1);
    else
      half_calc = HALF_W'(1) << exp_sel;
  end

  // Capture the half-period only while idle; hold it during a run.
  always_ff @(posedge clk) begin
    if (rst)
      half_q <= HALF_W'(1);
    else if (!en)
      half_q <= half_calc;
  end

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en)) |-> $stable(half_q));

  // R2
  half_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    half_q != '0);

endmodule

// File: rtl/sclk_period_cnt.sv
module sclk_period_cnt #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [HALF_W-1:0] half,
  output logic              wrap,
  output logic              tick
);

  logic [HALF_W-1:0] cnt;

  assign wrap = en && (cnt == half - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + HALF_W'(1);
      tick <= 1'b0;
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt < half));

  // R9
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0));

endmodule

// File: rtl/sclk_divgen.sv
module sclk_divgen
  import sclk_div_pkg::*;
#(
  parameter int   EXP_W    = 4,
  parameter int   LIN_W    = 8,
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             lin_mode,
  input  logic [EXP_W-1:0] exp_sel,
  input  logic [LIN_W-1:0] lin_div,
  output logic             tick,
  output logic             sclk
);

  localparam int HALF_W = half_width(EXP_W, LIN_W);

  logic [HALF_W-1:0] half_q;
  logic              wrap;

  sclk_ratio_sel #(
    .EXP_W (EXP_W),
    .LIN_W (LIN_W),
    .HALF_W(HALF_W)
  ) u_ratio (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .lin_mode(lin_mode),
    .exp_sel (exp_sel),
    .lin_div (lin_div),
    .half_q  (half_q)
  );

  sclk_period_cnt #(
    .HALF_W(HALF_W)
  ) u_cnt (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .half(half_q),
    .wrap(wrap),
    .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst || !en)
      sclk <= IDLE_LVL;
    else if (wrap)
      sclk <= ~sclk;
  end

  // R7
  tick_edge_chk: assert property (@(posedge clk) disable iff (rst)
    tick |-> (sclk != $past(sclk)));

  // R9
  idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ((sclk == IDLE_LVL) && !tick));

endmodule

// File: tb/sclk_divgen_bench.sv
`timescale 1ns/1ps
module sclk_divgen_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       en;
  logic       lin_mode;
  logic [3:0] exp_sel;
  logic [7:0] lin_div;
  logic       tick;
  logic       sclk;

  int unsigned n_run  = 0;
  int unsigned n_fail = 0;
  bit          done   = 1'b0;

  always #4 clk = ~clk;

  sclk_divgen u_sclk_divgen (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .lin_mode(lin_mode),
    .exp_sel (exp_sel),
    .lin_div (lin_div),
    .tick    (tick),
    .sclk    (sclk)
  );

  function automatic int unsigned exp_half(input logic m, input logic [3:0] e,
                                           input logic [7:0] n);
    return m ? (int'(n) + 1) : (1 << e);
  endfunction

  task automatic check(input bit ok, input string req, input int unsigned act,
                       input int unsigned expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_case(input logic m, input logic [3:0] e, input logic [7:0] n,
                          input int ntog, input bit perturb, input string req);
    int unsigned half;
    int unsigned cyc;
    int unsigned last;
    int          tog;
    logic        prev;
    bit          stray;
    half = exp_half(m, e, n);
    @(negedge clk);
    en = 1'b0; lin_mode = m; exp_sel = e; lin_div = n;
    repeat (2) @(negedge clk);
    en = 1'b1;
    prev = 1'b0; cyc = 0; last = 0; tog = 0; stray = 1'b0;
    while (tog < ntog && !stray) begin
      @(negedge clk);
      cyc++;
      if (sclk != prev) begin
        tog++;
        // R6 covers first interval, R2/R3/R4/R5 the spacing
        check(cyc - last == half, (tog == 1) ? "R6" : req, cyc - last, half);
        // R7
        check(tick == 1'b1, "R7", tick, 1);
        last = cyc;
        prev = sclk;
        if (perturb && tog == 1) begin
          // R8: fields change mid-run
          lin_mode = ~m; exp_sel = 4'($urandom_range(0, 15)); lin_div = 8'($urandom);
        end
      end else if (tick) begin
        check(1'b0, "R7", tick, 0);
        stray = 1'b1;
      end else if (cyc - last > half) begin
        check(1'b0, req, cyc - last, half);
        stray = 1'b1;
      end
    end
    en = 1'b0;
    @(negedge clk);
    // R9
    check(sclk == 1'b0 && tick == 1'b0, "R9", {sclk, tick}, 0);
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; lin_mode = 1'b0; exp_sel = '0; lin_div = '0;
    void'($urandom(32'h5eed_c10c));
    repeat (3) @(negedge clk);
    // R1
    check(sclk == 1'b0 && tick == 1'b0, "R1", {sclk, tick}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0 && tick == 1'b0, "R1", {sclk, tick}, 0);

    run_case(1'b1, 4'd0, 8'd0,   6, 1'b0, "R4");
    run_case(1'b0, 4'd0, 8'd0,   6, 1'b0, "R4");
    run_case(1'b1, 4'd0, 8'd255, 3, 1'b0, "R3");
    run_case(1'b0, 4'd3, 8'd0,   4, 1'b0, "R2");
    run_case(1'b1, 4'd0, 8'd4,   4, 1'b1, "R8");
    run_case(1'b0, 4'd5, 8'd9,   3, 1'b1, "R8");
    run_case(1'b0, 4'd15, 8'd0,  2, 1'b0, "R5");

    for (int i = 0; i < 12; i++) begin
      logic       m;
      logic [3:0] e;
      logic [7:0] n;
      m = 1'($urandom);
      e = 4'($urandom_range(0, 6));
      n = 8'($urandom);
      run_case(m, e, n, 3, 1'($urandom), m ? "R3" : "R2");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule